// File: doc/BRIEF.md
# Low-Power Mode Clock and Reset Sequencer

This block decides which clock domains of a small system-on-chip are allowed to tick and which modules are held in reset. It tracks one of five operating states: run, wait, doze, stop and standby. Each state maps to a set of clock enables: one for the CPU, one for the bus, one for the generic peripherals, and one each for the watchdog, the interval timer, the time-of-day timer and the keypad debounce logic. The timer and debounce enables are meant to gate a prescaled low-frequency reference, not the CPU clock.

While in run, the CPU asks for a low-power state by presenting a two-bit code with a valid strobe. Any qualified interrupt brings the chip back to run. A source is qualified when it is a peripheral interrupt whose wake-enable bit is set, or a keypad event while keypad wake is enabled. The low-voltage reset input forces standby, which wins over everything else. In standby every module reset hold is asserted, except those of the oscillator and the time-of-day timer. Two programmable bits choose whether the watchdog and the interval timer freeze in doze and stop.

All outputs are registered. They change on the clock edge that samples the causing input.

Top module: `lpm_clk_ctrl`

## Requirements
- R1: After asynchronous reset (rst_n low), mode_q is 0 (run), every clock enable is 1 and every bit of rst_hold is 0.
- R2: In run, a request with req_vld=1 and req_code 1, 2 or 3 moves mode_q to 1 (wait), 2 (doze) or 3 (stop) at the next edge. Code 0 is ignored. Requests made in any state other than run are ignored.
- R3: In wait, doze or stop, a qualified wake-up moves mode_q to 0 at the next edge, and cpu_clk_en and per_clk_en return to 1.
- R4: A qualified wake-up in the same cycle as an entry request in run keeps mode_q at 0.
- R5: In wait, cpu_clk_en is 0 and bus_clk_en, per_clk_en, wdog_clk_en and pit_clk_en are all 1.
- R6: In doze, cpu_clk_en and per_clk_en are 0 and bus_clk_en is 1. In stop, bus_clk_en is also 0.
- R7: In doze and stop, wdog_clk_en equals the inverse of frz_wdog as sampled at the previous edge. In run and wait it is 1.
- R8: In doze and stop, pit_clk_en equals the inverse of frz_pit as sampled at the previous edge. In run and wait it is 1.
- R9: tod_clk_en and kpd_clk_en are 1 in every state, standby included.
- R10: Bit i of irq wakes only if irq_wake_en[i] is 1. kpd_evt wakes only if kpd_wake_en is 1. An unqualified event leaves the state unchanged.
- R11: lv_rst=1 moves mode_q to 4 (standby) at the next edge, over any request or wake-up. In standby, rst_hold is 8'h3F (bits 0 to 5 are CPU, bus, peripherals, watchdog, interval timer and keypad; bit 6 is the oscillator and bit 7 is the time-of-day timer, both 0). Every clock enable is 0 except tod_clk_en and kpd_clk_en.
- R12: In standby, lv_rst=0 moves mode_q to 0 at the next edge, with rst_hold 0 and all enables back to their run values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lv_rst | input | 1 | Low-voltage reset, selects standby |
| req_vld | input | 1 | CPU low-power request strobe |
| req_code | input | 2 | Requested state: 1 wait, 2 doze, 3 stop |
| irq | input | NIRQ | Peripheral interrupt lines |
| irq_wake_en | input | NIRQ | Per-line wake-up enable |
| kpd_evt | input | 1 | Keypad event |
| kpd_wake_en | input | 1 | Keypad wake-up enable |
| frz_wdog | input | 1 | Freeze watchdog in doze and stop |
| frz_pit | input | 1 | Freeze interval timer in doze and stop |
| mode_q | output | 3 | Current state: 0 run, 1 wait, 2 doze, 3 stop, 4 standby |
| cpu_clk_en | output | 1 | CPU clock enable |
| bus_clk_en | output | 1 | Bus clock enable |
| per_clk_en | output | 1 | Generic peripheral clock enable |
| wdog_clk_en | output | 1 | Watchdog reference enable |
| pit_clk_en | output | 1 | Interval timer reference enable |
| tod_clk_en | output | 1 | Time-of-day reference enable |
| kpd_clk_en | output | 1 | Keypad debounce reference enable |
| rst_hold | output | 8 | Per-module reset holds (bit map in R11) |

## Verification
Two pairs of events can land on the same edge: a wake-up with an entry request, and the low-voltage reset with a wake-up. The bench drives each pair in one cycle. For the first pair it expects the state to stay in run. For the second it expects standby, and it holds the wake-up during standby to confirm that only releasing lv_rst ends it. Every check compares the full output bundle against a value built in the bench from the state it expects and the freeze bits it drove.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [2:0] {
        M_RUN  = 3'd0,
        M_WAIT = 3'd1,
        M_DOZE = 3'd2,
        M_STOP = 3'd3,
        M_STBY = 3'd4
    } lpm_mode_e;

    localparam int NMOD     = 8;
    localparam int H_CPU    = 0;
    localparam int H_BUS    = 1;
    localparam int H_PER    = 2;
    localparam int H_WDOG   = 3;
    localparam int H_PIT    = 4;
    localparam int H_KPD    = 5;
    localparam int H_OSC    = 6;
    localparam int H_TOD    = 7;

    typedef struct packed {
        logic            cpu;
        logic            bus;
        logic            per;
        logic            wdog;
        logic            pit;
        logic            tod;
        logic            kpd;
        logic [NMOD-1:0] hold;
    } gate_s;

endpackage

// File: rtl/lpm_wake_merge.sv
module lpm_wake_merge #(
    parameter int NIRQ = 4
) (
    input  logic [NIRQ-1:0] irq,
    input  logic [NIRQ-1:0] irq_wake_en,
    input  logic            kpd_evt,
    input  logic            kpd_wake_en,
    output logic            wake
);
    logic [NIRQ-1:0] qual;

    for (genvar i = 0; i < NIRQ; i++) begin : g_qual
        assign qual[i] = irq[i] & irq_wake_en[i];
    end

    assign wake = (|qual) | (kpd_evt & kpd_wake_en);
endmodule

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
    import lpm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      lv_rst,
    input  logic      req_vld,
    input  logic [1:0] req_code,
    input  logic      wake,
    output lpm_mode_e mode_d,
    output lpm_mode_e mode_q
);
    typedef struct packed {
        lpm_mode_e mode;
    } st_s;

    st_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (lv_rst) begin
            st_d.mode = M_STBY;
        end else if (st_q.mode == M_STBY) begin
            st_d.mode = M_RUN;
        end else if (wake) begin
            st_d.mode = M_RUN;
        end else if (st_q.mode == M_RUN && req_vld && req_code != 2'd0) begin
            st_d.mode = lpm_mode_e'({1'b0, req_code});
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mode: M_RUN};
        else        st_q <= st_d;
    end

    assign mode_d = st_d.mode;
    assign mode_q = st_q.mode;
endmodule

// File: rtl/lpm_gate_map.sv
module lpm_gate_map
    import lpm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  lpm_mode_e mode_d,
    input  logic      frz_wdog,
    input  logic      frz_pit,
    output gate_s     gate_q
);
    localparam logic [NMOD-1:0] STBY_HOLD =
        ~((NMOD'(1) << H_OSC) | (NMOD'(1) << H_TOD));
    localparam gate_s RUN_GATE = '{cpu: 1'b1, bus: 1'b1, per: 1'b1, wdog: 1'b1,
                                   pit: 1'b1, tod: 1'b1, kpd: 1'b1, hold: '0};

    gate_s gate_d;
    logic  deep;

    always_comb begin
        deep   = (mode_d == M_DOZE) || (mode_d == M_STOP);
        gate_d = RUN_GATE;
        case (mode_d)
            M_WAIT: gate_d.cpu = 1'b0;
            M_DOZE: begin
                gate_d.cpu = 1'b0;
                gate_d.per = 1'b0;
            end
            M_STOP: begin
                gate_d.cpu = 1'b0;
                gate_d.per = 1'b0;
                gate_d.bus = 1'b0;
            end
            M_STBY: begin
                gate_d.cpu  = 1'b0;
                gate_d.per  = 1'b0;
                gate_d.bus  = 1'b0;
                gate_d.hold = STBY_HOLD;
            end
            default: ;
        endcase
        if (mode_d == M_STBY) begin
            gate_d.wdog = 1'b0;
            gate_d.pit  = 1'b0;
        end else if (deep) begin
            gate_d.wdog = !frz_wdog;
            gate_d.pit  = !frz_pit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gate_q <= RUN_GATE;
        else        gate_q <= gate_d;
    end
endmodule

// File: rtl/lpm_clk_ctrl.sv
module lpm_clk_ctrl
    import lpm_pkg::*;
#(
    parameter int NIRQ = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lv_rst,
    input  logic            req_vld,
    input  logic [1:0]      req_code,
    input  logic [NIRQ-1:0] irq,
    input  logic [NIRQ-1:0] irq_wake_en,
    input  logic            kpd_evt,
    input  logic            kpd_wake_en,
    input  logic            frz_wdog,
    input  logic            frz_pit,
    output logic [2:0]      mode_q,
    output logic            cpu_clk_en,
    output logic            bus_clk_en,
    output logic            per_clk_en,
    output logic            wdog_clk_en,
    output logic            pit_clk_en,
    output logic            tod_clk_en,
    output logic            kpd_clk_en,
    output logic [7:0]      rst_hold
);
    logic      wake;
    lpm_mode_e mode_d, mode_r;
    gate_s     gate_q;

    lpm_wake_merge #(.NIRQ(NIRQ)) u_wake (
        .irq         (irq),
        .irq_wake_en (irq_wake_en),
        .kpd_evt     (kpd_evt),
        .kpd_wake_en (kpd_wake_en),
        .wake        (wake)
    );

    lpm_mode_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .lv_rst   (lv_rst),
        .req_vld  (req_vld),
        .req_code (req_code),
        .wake     (wake),
        .mode_d   (mode_d),
        .mode_q   (mode_r)
    );

    lpm_gate_map u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_d   (mode_d),
        .frz_wdog (frz_wdog),
        .frz_pit  (frz_pit),
        .gate_q   (gate_q)
    );

    assign mode_q      = mode_r;
    assign cpu_clk_en  = gate_q.cpu;
    assign bus_clk_en  = gate_q.bus;
    assign per_clk_en  = gate_q.per;
    assign wdog_clk_en = gate_q.wdog;
    assign pit_clk_en  = gate_q.pit;
    assign tod_clk_en  = gate_q.tod;
    assign kpd_clk_en  = gate_q.kpd;
    assign rst_hold    = gate_q.hold;

    // R11: low-voltage reset always lands in standby
    p_stby_entry_r11: assert property (@(posedge clk) disable iff (!rst_n)
        lv_rst |=> (mode_q == 3'd4 && rst_hold == 8'h3F && !cpu_clk_en));

    // R12: releasing low-voltage reset returns to run with holds cleared
    p_stby_exit_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 3'd4 && !lv_rst) |=> (mode_q == 3'd0 && rst_hold == 8'h00));

    // R3: qualified wake from a low-power state
    p_wake_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q inside {3'd1, 3'd2, 3'd3} && wake && !lv_rst)
        |=> (mode_q == 3'd0 && cpu_clk_en && per_clk_en));

    // R2: requests outside run do not move the state
    p_req_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q inside {3'd1, 3'd2, 3'd3} && !wake && !lv_rst)
        |=> (mode_q == $past(mode_q)));

    // R5: wait gates only the CPU
    p_wait_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 3'd1) |-> (!cpu_clk_en && bus_clk_en && per_clk_en));

    // R6: stop gates the bus and peripherals
    p_stop_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 3'd3) |-> (!bus_clk_en && !per_clk_en && !cpu_clk_en));

    // R7: watchdog freeze follows its bit in doze and stop
    p_wdog_frz_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q inside {3'd2, 3'd3}) |-> (wdog_clk_en == !$past(frz_wdog)));

    // R4: wake together with a request keeps run
    p_wake_vs_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 3'd0 && wake && !lv_rst) |=> (mode_q == 3'd0));
endmodule

// File: tb/lpm_clk_ctrl_tb.sv
module lpm_clk_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NIRQ = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lv_rst = 1'b0, req_vld = 1'b0, kpd_evt = 1'b0, kpd_wake_en = 1'b0;
    logic frz_wdog = 1'b0, frz_pit = 1'b0;
    logic [1:0] req_code = 2'd0;
    logic [NIRQ-1:0] irq = '0, irq_wake_en = '0;
    logic [2:0] mode_q;
    logic cpu_clk_en, bus_clk_en, per_clk_en, wdog_clk_en, pit_clk_en, tod_clk_en, kpd_clk_en;
    logic [7:0] rst_hold;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lpm_clk_ctrl #(.NIRQ(NIRQ)) u_dut (
        .clk(clk), .rst_n(rst_n), .lv_rst(lv_rst), .req_vld(req_vld), .req_code(req_code),
        .irq(irq), .irq_wake_en(irq_wake_en), .kpd_evt(kpd_evt), .kpd_wake_en(kpd_wake_en),
        .frz_wdog(frz_wdog), .frz_pit(frz_pit), .mode_q(mode_q),
        .cpu_clk_en(cpu_clk_en), .bus_clk_en(bus_clk_en), .per_clk_en(per_clk_en),
        .wdog_clk_en(wdog_clk_en), .pit_clk_en(pit_clk_en), .tod_clk_en(tod_clk_en),
        .kpd_clk_en(kpd_clk_en), .rst_hold(rst_hold)
    );

    // expected bundle {mode, cpu, bus, per, wdog, pit, tod, kpd, hold}
    function automatic logic [17:0] expect_of(input int m, input logic fw, input logic fp);
        logic cpu, bus, per, wd, pt;
        logic [7:0] h;
        cpu = (m == 0);
        bus = (m <= 2);
        per = (m <= 1);
        wd  = (m == 4) ? 1'b0 : ((m == 2 || m == 3) ? !fw : 1'b1);
        pt  = (m == 4) ? 1'b0 : ((m == 2 || m == 3) ? !fp : 1'b1);
        h   = (m == 4) ? 8'h3F : 8'h00;
        return {3'(m), cpu, bus, per, wd, pt, 1'b1, 1'b1, h};
    endfunction

    task automatic check(input string rtag, input int m);
        logic [17:0] act, exp;
        act = {mode_q, cpu_clk_en, bus_clk_en, per_clk_en, wdog_clk_en, pit_clk_en,
               tod_clk_en, kpd_clk_en, rst_hold};
        exp = expect_of(m, frz_wdog, frz_pit);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", rtag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        req_vld = 1'b0; req_code = 2'd0; irq = '0; kpd_evt = 1'b0; lv_rst = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        irq_wake_en = '1;
        kpd_wake_en = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 reset", 0);
        rst_n = 1'b1;
        step();
        check("R1 after release", 0);

        // sweep every low-power state with every freeze combination
        for (int m = 1; m <= 3; m++) begin
            for (int f = 0; f < 4; f++) begin
                frz_wdog = f[0]; frz_pit = f[1];
                req_vld = 1'b1; req_code = 2'(m);
                step();
                check("R2/R5/R6/R7/R8/R9 entry", m);
                req_code = 2'(m == 3 ? 1 : 3);
                step();
                check("R2 request ignored outside run", m);
                req_vld = 1'b0;
                frz_wdog = !frz_wdog;
                step();
                check("R7 freeze bit change while low power", m);
                irq = '0; irq[(m + f) % NIRQ] = 1'b1;
                step();
                check("R3 wake to run", 0);
                idle();
            end
        end

        // code 0 ignored
        frz_wdog = 1'b0; frz_pit = 1'b0;
        req_vld = 1'b1; req_code = 2'd0;
        step();
        check("R2 code zero ignored", 0);

        // wake in the same cycle as a request
        for (int m = 1; m <= 3; m++) begin
            req_vld = 1'b1; req_code = 2'(m); kpd_evt = 1'b1;
            step();
            check("R4 wake with request", 0);
        end
        idle();

        // masked sources
        req_vld = 1'b1; req_code = 2'd3;
        step();
        check("R10 enter stop", 3);
        req_vld = 1'b0;
        for (int i = 0; i < NIRQ; i++) begin
            irq_wake_en = '1; irq_wake_en[i] = 1'b0;
            irq = '0; irq[i] = 1'b1;
            step();
            check("R10 masked irq ignored", 3);
        end
        irq = '0; irq_wake_en = '1;
        kpd_wake_en = 1'b0; kpd_evt = 1'b1;
        step();
        check("R10 masked keypad ignored", 3);
        kpd_wake_en = 1'b1;
        step();
        check("R10 keypad wake", 0);
        idle();

        // standby wins over wake and request
        req_vld = 1'b1; req_code = 2'd2;
        step();
        check("R11 enter doze", 2);
        lv_rst = 1'b1; irq = '1; req_code = 2'd1;
        step();
        check("R11 standby over wake", 4);
        repeat (3) begin
            step();
            check("R11 standby held", 4);
        end
        lv_rst = 1'b0; irq = '0; req_vld = 1'b0;
        step();
        check("R12 standby exit", 0);
        lv_rst = 1'b1; req_vld = 1'b1; req_code = 2'd3; kpd_evt = 1'b1;
        step();
        check("R11 standby from run", 4);
        idle();
        step();
        check("R12 release to run", 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule